// File: doc/BRIEF.md
# UART Interrupt Register Bank

This block keeps the pending-interrupt bits of a serial port with four sources: transmit level reached, receive level reached, transmit drained and receive overrun. The datapath reports each source as a one-cycle event pulse. Software sees three 32-bit registers through a simple write/read port addressed by byte offset. One register holds the pending bits, one holds the per-source mask, and one lets software raise pending bits for test.

Pending bits are cleared by writing ones to them. Writes of zero leave them alone, so software can acknowledge one source without disturbing the others. Each source drives its own level-sensitive interrupt line. The line is registered and goes high while the source is both pending and unmasked.

Top module: `uart_irq_bank`

## Requirements
- R1: Source index i (0 transmit level, 1 receive level, 2 transmit drained, 3 receive overrun) uses bit i of `evt_i`, bit i of the pending register and bit i of `irq_o`.
- R2: An event pulse on `evt_i[i]` sets pending bit i on the clock edge that samples it, and a later read of offset 0x00 shows it.
- R3: A write to offset 0x00 clears each pending bit whose `wdata` bit is 1 and leaves the pending bits whose `wdata` bit is 0 unchanged.
- R4: When the same edge sees a clear of pending bit i and an event on source i, the bit ends up set.
- R5: A write to offset 0x08 ORs `wdata[3:0]` into the pending bits, and bits 31:4 of that write have no effect.
- R6: A read of offset 0x08 returns zero and changes no pending or mask bit.
- R7: Offset 0x04 is the mask register: a write stores `wdata[3:0]`, and a read returns those bits with bits 31:4 zero.
- R8: `irq_o[i]` equals (pending bit i AND mask bit i) as they stood one clock earlier, so it follows a change of either with one cycle of lag.
- R9: While `rst_n` is low, pending bits, mask bits, `rdata` and `irq_o` are all zero.
- R10: Reads of any offset other than 0x00, 0x04 and 0x08 return zero, and writes to such offsets change no pending or mask bit.
- R11: `rdata` is registered. After an edge with `rd_en` high it holds the addressed register as it was before that edge. After an edge with `rd_en` low it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 4 | One-cycle event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_o | output | 4 | Per-source interrupt lines |

## Verification
Single-source event pulses, one per source index, show whether the bit routing from event to pending bit and line is right. Acknowledge writes with mixed one/zero patterns distinguish a true write-one-to-clear from a plain overwrite. Acknowledges that coincide with an event on the same source expose the wrong priority. Test-register writes with high garbage bits, reads of the test and unmapped offsets, and a long pseudo-random mix of all access kinds check the masking lag, the read-side zeros and that no stray access changes any state.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;

  localparam int OFF_PEND = 'h00;
  localparam int OFF_MASK = 'h04;
  localparam int OFF_TEST = 'h08;

  typedef enum int {
    SRC_TX_LEVEL = 0,
    SRC_RX_LEVEL = 1,
    SRC_TX_DRAIN = 2,
    SRC_RX_OVRUN = 3
  } src_idx_e;

  // One pending bit: clear on request, set dominates.
  function automatic logic pend_next(logic cur, logic clr, logic set);
    return (cur & ~clr) | set;
  endfunction

  // Line level for one source.
  function automatic logic line_level(logic pend, logic mask);
    return pend & mask;
  endfunction
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic          wr_pend,
  output logic          wr_mask,
  output logic          wr_test,
  output logic          rd_pend,
  output logic          rd_mask,
  output logic          hit_any
);
  logic at_pend, at_mask, at_test;

  assign at_pend = (addr == AW'(OFF_PEND));
  assign at_mask = (addr == AW'(OFF_MASK));
  assign at_test = (addr == AW'(OFF_TEST));
  assign hit_any = at_pend | at_mask | at_test;

  assign wr_pend = wr_en & at_pend;
  assign wr_mask = wr_en & at_mask;
  assign wr_test = wr_en & at_test;
  assign rd_pend = rd_en & at_pend;
  assign rd_mask = rd_en & at_mask;
endmodule

// File: rtl/uart_irq_pend_cell.sv
module uart_irq_pend_cell
  import uart_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_hw,
  input  logic set_sw,
  input  logic clr_sw,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= pend_next(q, clr_sw, set_hw | set_sw);
  end
endmodule

// File: rtl/uart_irq_out_stage.sv
module uart_irq_out_stage
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] mask,
  output logic [N-1:0] line
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) line[i] <= 1'b0;
      else        line[i] <= line_level(pend[i], mask[i]);
    end
  end
endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
  import uart_irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NSRC-1:0] irq_o
);
  logic            wr_pend, wr_mask, wr_test, rd_pend, rd_mask, hit_any;
  logic [NSRC-1:0] pend_q, mask_q;
  logic [NSRC-1:0] wlow;
  logic [DW-1:0]   rd_val;
  logic            unused_whigh;

  assign wlow         = wdata[NSRC-1:0];
  assign unused_whigh = ^wdata[DW-1:NSRC];

  uart_irq_decode #(.AW(AW)) u_dec (
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_pend (wr_pend),
    .wr_mask (wr_mask),
    .wr_test (wr_test),
    .rd_pend (rd_pend),
    .rd_mask (rd_mask),
    .hit_any (hit_any)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_pend
    uart_irq_pend_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_hw (evt_i[i]),
      .set_sw (wr_test & wlow[i]),
      .clr_sw (wr_pend & wlow[i]),
      .q      (pend_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wlow;
  end

  always_comb begin
    rd_val = '0;
    if (rd_pend)      rd_val[NSRC-1:0] = pend_q;
    else if (rd_mask) rd_val[NSRC-1:0] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_val;
  end

  uart_irq_out_stage #(.N(NSRC)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_q),
    .mask  (mask_q),
    .line  (irq_o)
  );
endmodule

// File: rtl/uart_irq_bank_chk.sv
module uart_irq_bank_chk
  import uart_irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_i,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic [NSRC-1:0] irq_o,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic            wr_pend,
  input logic            wr_test,
  input logic            hit_any
);
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && evt_i == '0) |=> ((pend_q & $past(wdata[NSRC-1:0])) == '0)); // R3

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && ((wdata[NSRC-1:0] & evt_i) != '0))
      |=> ((pend_q & $past(wdata[NSRC-1:0] & evt_i)) == $past(wdata[NSRC-1:0] & evt_i))); // R4

  AST_TEST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_test |=> ((pend_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0]))); // R5

  AST_TEST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(OFF_TEST)) |=> (rdata == '0)); // R6

  AST_LINE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(pend_q & mask_q)); // R8

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_any) |=> $stable(mask_q)); // R10

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0)); // R11
endmodule

bind uart_irq_bank uart_irq_bank_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_i   (evt_i),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq_o   (irq_o),
  .pend_q  (pend_q),
  .mask_q  (mask_q),
  .wr_pend (wr_pend),
  .wr_test (wr_test),
  .hit_any (hit_any)
);

// File: tb/sim_uart_irq_bank.sv
`timescale 1ns/1ps
module sim_uart_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt_i = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int          due;
    bit          is_line;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  logic [3:0] m_pend = '0;
  logic [3:0] m_mask = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compare every scoreboard item that falls due this cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = sbq.size() - 1; k >= 0; k--) begin
        if (sbq[k].due == cyc) begin
          if (sbq[k].is_line) check({28'd0, irq_o}, sbq[k].exp, sbq[k].tag);
          else                check(rdata, sbq[k].exp, sbq[k].tag);
          sbq.delete(k);
        end
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return {28'd0, m_pend};
      8'h04:   return {28'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  // Driver: one cycle of stimulus, expectations pushed into the scoreboard.
  task automatic op(input bit w, input bit r, input logic [7:0] a,
                    input logic [31:0] d, input logic [3:0] e, input string tag);
    logic [3:0] clr, set;
    item_t it;
    wr_en = w; rd_en = r; addr = a; wdata = d; evt_i = e;
    it.due = cyc + 1; it.is_line = 1'b0;
    it.exp = r ? model_read(a) : 32'd0;
    it.tag = r ? tag : "R11 idle rdata";
    sbq.push_back(it);
    clr = (w && a == 8'h00) ? d[3:0] : 4'd0;
    set = e | ((w && a == 8'h08) ? d[3:0] : 4'd0);
    m_pend = (m_pend & ~clr) | set;
    if (w && a == 8'h04) m_mask = d[3:0];
    it.due = cyc + 2; it.is_line = 1'b1;
    it.exp = {28'd0, m_pend & m_mask};
    it.tag = {tag, " / R8 line"};
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 8'h00, 32'd0, 4'd0, "idle");
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    logic [7:0]  a;
    repeat (3) @(negedge clk);
    check(rdata, 32'd0, "R9 rdata in reset");
    check({28'd0, irq_o}, 32'd0, "R9 irq in reset");
    rst_n = 1'b1;
    @(negedge clk);
    op(1'b0, 1'b1, 8'h00, 0, 0, "R9 pending after reset");
    op(1'b0, 1'b1, 8'h04, 0, 0, "R9 mask after reset");

    op(1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF, 0, "R7 mask write");
    op(1'b0, 1'b1, 8'h04, 0, 0, "R7 mask read high bits zero");

    for (int i = 0; i < 4; i++) begin
      op(1'b0, 1'b0, 8'h00, 0, 4'(1 << i), "R1 source event");
      op(1'b0, 1'b1, 8'h00, 0, 0, "R1 R2 pending readback");
      idle(1);
      op(1'b1, 1'b0, 8'h00, 32'h0000_000F, 0, "R3 clear all");
    end

    op(1'b0, 1'b0, 8'h00, 0, 4'b0101, "R2 two events");
    op(1'b0, 1'b0, 8'h00, 0, 4'b0010, "R2 third event");
    op(1'b1, 1'b0, 8'h00, 32'h0000_0003, 0, "R3 partial clear");
    op(1'b0, 1'b1, 8'h00, 0, 0, "R3 only written ones cleared");
    op(1'b1, 1'b0, 8'h00, 32'h0000_0004, 4'b0100, "R4 set beats clear");
    op(1'b0, 1'b1, 8'h00, 0, 0, "R4 bit survives");

    op(1'b1, 1'b0, 8'h08, 32'hFFFF_FFF8, 0, "R5 test sets bit 3");
    op(1'b0, 1'b1, 8'h00, 0, 0, "R5 pending after test");
    op(1'b0, 1'b1, 8'h08, 0, 0, "R6 test reads zero");
    op(1'b0, 1'b1, 8'h00, 0, 0, "R6 pending unchanged");

    op(1'b1, 1'b0, 8'h0C, 32'hFFFF_FFFF, 0, "R10 unmapped write");
    op(1'b1, 1'b0, 8'h01, 32'hFFFF_FFFF, 0, "R10 unaligned write");
    op(1'b0, 1'b1, 8'h0C, 0, 0, "R10 unmapped read");
    op(1'b0, 1'b1, 8'h04, 0, 0, "R10 mask unchanged");
    op(1'b0, 1'b1, 8'h00, 0, 0, "R10 pending unchanged");

    op(1'b1, 1'b0, 8'h04, 32'h0000_0001, 0, "R8 mask narrowed");
    op(1'b1, 1'b0, 8'h08, 32'h0000_0001, 0, "R8 unmasked source");
    idle(2);

    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: a = 8'h00;
        3'd2:       a = 8'h04;
        3'd3:       a = 8'h08;
        default:    a = {lfsr[9:4], 2'b00};
      endcase
      op(lfsr[3], !lfsr[3] && lfsr[11], a, {lfsr, lfsr}, (lfsr[15:14] == 2'b00) ? lfsr[7:4] : 4'd0,
         "R2 R3 R4 R5 R7 R10 mixed traffic");
    end
    idle(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule